// File: doc/BRIEF.md
# Four-Lane Byte/Word Transfer Buffer

This block holds the data of a serial port controller in both directions. Each direction has four byte-wide lanes of 16 entries each. The bus side reaches the lanes in two ways. A 32-bit access moves one byte in every lane at once, so a direction holds 64 bytes through it. An 8-bit access touches lane 0 only, so a direction holds 16 bytes through it. The serial engine side always moves a single byte. In word mode it walks the lanes in the order 0, 1, 2, 3 and then wraps. In byte mode it stays on lane 0.

The mode is taken from `xfer_word` on the cycle `xfer_start` is high, and it holds until the next start. The transmit side reports full, half-full and empty. The receive side reports full, half-full, word-available and byte-available. Each flag follows from the lane fill counts that the mode selects. Accesses that cannot complete are dropped and raise `illegal_access` for one cycle. A soft reset empties all eight lanes.

Top module: `quad_lane_fifo`

## Requirements
- R1: After `rst_n` is released, `tx_empty`=1, and `tx_full`, `tx_half`, `rx_full`, `rx_half`, `rx_word_avail`, `rx_byte_avail` and `illegal_access` are all 0. The mode is byte mode.
- R2: In word mode, a word written to `tx_wdata` puts bits [8k+7:8k] into lane k. The serial side takes bytes in lane order 0,1,2,3 and repeats, and `ser_tx_byte` shows the byte that the next `ser_tx_take` removes. In word mode `tx_empty` is 1 exactly when all four transmit lanes are empty.
- R3: In byte mode, byte writes (`tx_wdata[7:0]`) and serial takes both use transmit lane 0 in first-in first-out order.
- R4: `tx_full` is 1 when any transmit lane holds 16 bytes (word mode) or when lane 0 holds 16 bytes (byte mode). This gives 16 word writes (64 bytes) or 16 byte writes of capacity.
- R5: `tx_half` is 1 when the four transmit lanes together hold at least 32 bytes (word mode) or when lane 0 holds at least 8 bytes (byte mode).
- R6: In word mode, each `ser_rx_put` byte goes to receive lanes 0,1,2,3 in rotation. `rx_word_avail` is 1 when all four receive lanes hold data. A word read (`rx_rd_word`) pops one byte from each lane, and `rx_rdata` shows lane k's oldest byte in bits [8k+7:8k].
- R7: `rx_byte_avail` is 1 when receive lane 0 holds data. A byte read (`rx_rd_byte`) pops lane 0 only, and its data is `rx_rdata[7:0]`.
- R8: `rx_full` and `rx_half` use the same rules as `tx_full` and `tx_half`, applied to the receive lanes.
- R9: The following accesses are dropped without any change to the lanes, and `illegal_access` is 1 on the cycle after each one:
  - a word write when any transmit lane is full;
  - a byte write when transmit lane 0 is full;
  - a serial take from an empty selected lane;
  - a serial put into a full selected lane;
  - a word read when any receive lane is empty;
  - a byte read when receive lane 0 is empty;
  - a word strobe and a byte strobe on the same side in the same cycle.
- R10: `soft_rst` empties every lane in both directions and returns both serial lane selectors to lane 0. This takes priority over any access in the same cycle.
- R11: The mode changes only on a cycle with `xfer_start`=1, and it takes effect from the next cycle. A start also returns both serial lane selectors to lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Empties all lanes in both directions |
| xfer_start | input | 1 | Transaction start, latches the mode |
| xfer_word | input | 1 | 1 = word mode, 0 = byte mode (sampled on start) |
| tx_wr_word | input | 1 | 32-bit write to transmit lanes |
| tx_wr_byte | input | 1 | 8-bit write to transmit lane 0 |
| tx_wdata | input | 32 | Transmit write data |
| tx_full | output | 1 | Transmit full |
| tx_half | output | 1 | Transmit half-full |
| tx_empty | output | 1 | Transmit empty |
| ser_tx_take | input | 1 | Serial engine removes one transmit byte |
| ser_tx_byte | output | 8 | Next transmit byte for the serial engine |
| ser_rx_put | input | 1 | Serial engine inserts one receive byte |
| ser_rx_byte | input | 8 | Received byte from the serial engine |
| rx_rd_word | input | 1 | 32-bit read from receive lanes |
| rx_rd_byte | input | 1 | 8-bit read from receive lane 0 |
| rx_rdata | output | 32 | Oldest byte of each receive lane |
| rx_full | output | 1 | Receive full |
| rx_half | output | 1 | Receive half-full |
| rx_word_avail | output | 1 | Each receive lane holds at least one byte |
| rx_byte_avail | output | 1 | Receive lane 0 holds at least one byte |
| illegal_access | output | 1 | One-cycle pulse after a dropped access |

## Verification
The hardest state to reach is one where the four lanes of a side hold different fill levels. This happens when a word-mode transaction ends partway through a lane rotation and is then followed by byte accesses or a new start. In that state the word flags and the byte flags disagree, and the lane selector must be back at lane 0.

Random stimulus produces it by starting a new transaction with a random mode at random points. Soft resets are mixed in, and word and byte strobes on both sides are driven with random overlap. Directed sequences cover exact capacity in each mode, one access past capacity, and a word read attempted on three bytes of receive data.

// File: rtl/qlf_pkg.sv
package qlf_pkg;
    localparam int LANE_W = 8;

    typedef enum logic {
        MODE_BYTE = 1'b0,
        MODE_WORD = 1'b1
    } xfer_mode_e;
endpackage

// File: rtl/qlf_lane.sv
// One byte-wide lane: circular store with fill count, show-ahead head.
module qlf_lane #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      push,
    input  logic                      pop,
    input  logic [qlf_pkg::LANE_W-1:0] wdata,
    output logic [qlf_pkg::LANE_W-1:0] head,
    output logic [CW-1:0]             count
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } lane_st_t;

    lane_st_t st_d, st_q;
    logic [qlf_pkg::LANE_W-1:0] mem_q [DEPTH];

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            if (push) st_d.wp = st_q.wp + AW'(1);
            if (pop)  st_d.rp = st_q.rp + AW'(1);
            st_d.cnt = st_q.cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push && !clr) mem_q[st_q.wp] <= wdata;
    end

    assign head  = mem_q[st_q.rp];
    assign count = st_q.cnt;
endmodule

// File: rtl/qlf_side.sv
// One direction: LANES parallel lanes, bus side word/byte, serial side byte.
// BUS_FILLS=1: bus pushes, serial pops (transmit). 0: the reverse (receive).
module qlf_side #(
    parameter bit BUS_FILLS = 1'b1,
    parameter int LANES     = 4,
    parameter int DEPTH     = 16,
    localparam int BW       = qlf_pkg::LANE_W,
    localparam int WW       = BW * LANES,
    localparam int CW       = $clog2(DEPTH + 1),
    localparam int LW       = $clog2(LANES),
    localparam int TW       = $clog2(LANES * DEPTH + 1),
    localparam int HALF_ALL = LANES * DEPTH / 2,
    localparam int HALF_ONE = DEPTH / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          restart,
    input  logic          word_mode,
    input  logic          bus_word,
    input  logic          bus_byte,
    input  logic [WW-1:0] bus_wdata,
    output logic [WW-1:0] bus_rdata,
    input  logic          ser_stb,
    input  logic [BW-1:0] ser_wdata,
    output logic [BW-1:0] ser_rdata,
    output logic          full,
    output logic          half,
    output logic          empty,
    output logic          word_avail,
    output logic          byte_avail,
    output logic          illegal
);
    typedef struct packed {
        logic [LW-1:0] sel;
        logic          err;
    } side_st_t;

    side_st_t st_d, st_q;

    logic [CW-1:0]    cnt  [LANES];
    logic [BW-1:0]    head [LANES];
    logic [BW-1:0]    lwd  [LANES];
    logic [LANES-1:0] push, pop, full_l, empty_l;
    logic [TW-1:0]    tot;
    logic [LW-1:0]    sel_lane;
    logic             both, w_ok, b_ok, s_ok;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        qlf_lane #(.DEPTH(DEPTH)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .push  (push[g]),
            .pop   (pop[g]),
            .wdata (lwd[g]),
            .head  (head[g]),
            .count (cnt[g])
        );
        assign full_l[g]            = (cnt[g] == CW'(DEPTH));
        assign empty_l[g]           = (cnt[g] == '0);
        assign bus_rdata[BW*g +: BW] = head[g];
    end

    always_comb begin
        tot = '0;
        for (int i = 0; i < LANES; i++) tot = tot + TW'(cnt[i]);
    end

    assign sel_lane = word_mode ? st_q.sel : '0;

    always_comb begin
        both = bus_word & bus_byte;
        if (BUS_FILLS) begin
            w_ok = bus_word & ~both & ~|full_l;
            b_ok = bus_byte & ~both & ~full_l[0];
            s_ok = ser_stb & ~empty_l[sel_lane];
        end else begin
            w_ok = bus_word & ~both & ~|empty_l;
            b_ok = bus_byte & ~both & ~empty_l[0];
            s_ok = ser_stb & ~full_l[sel_lane];
        end

        for (int i = 0; i < LANES; i++) begin
            if (BUS_FILLS) begin
                push[i] = w_ok | (b_ok & (i == 0));
                pop[i]  = s_ok & (sel_lane == LW'(i));
                lwd[i]  = bus_word ? bus_wdata[BW*i +: BW] : bus_wdata[BW-1:0];
            end else begin
                push[i] = s_ok & (sel_lane == LW'(i));
                pop[i]  = w_ok | (b_ok & (i == 0));
                lwd[i]  = ser_wdata;
            end
        end

        st_d     = st_q;
        st_d.err = ((bus_word | bus_byte) & ~(w_ok | b_ok)) | (ser_stb & ~s_ok);
        if (clr || restart)          st_d.sel = '0;
        else if (s_ok && word_mode)  st_d.sel = st_q.sel + LW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full       = word_mode ? |full_l  : full_l[0];
    assign empty      = word_mode ? &empty_l : empty_l[0];
    assign half       = word_mode ? (tot >= TW'(HALF_ALL)) : (cnt[0] >= CW'(HALF_ONE));
    assign word_avail = ~|empty_l;
    assign byte_avail = ~empty_l[0];
    assign ser_rdata  = head[sel_lane];
    assign illegal    = st_q.err;
endmodule

// File: rtl/quad_lane_fifo.sv
module quad_lane_fifo #(
    parameter int LANES = 4,
    parameter int DEPTH = 16,
    localparam int BW   = qlf_pkg::LANE_W,
    localparam int WW   = BW * LANES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          xfer_start,
    input  logic          xfer_word,
    input  logic          tx_wr_word,
    input  logic          tx_wr_byte,
    input  logic [WW-1:0] tx_wdata,
    output logic          tx_full,
    output logic          tx_half,
    output logic          tx_empty,
    input  logic          ser_tx_take,
    output logic [BW-1:0] ser_tx_byte,
    input  logic          ser_rx_put,
    input  logic [BW-1:0] ser_rx_byte,
    input  logic          rx_rd_word,
    input  logic          rx_rd_byte,
    output logic [WW-1:0] rx_rdata,
    output logic          rx_full,
    output logic          rx_half,
    output logic          rx_word_avail,
    output logic          rx_byte_avail,
    output logic          illegal_access
);
    import qlf_pkg::*;

    typedef struct packed {
        xfer_mode_e mode;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    word_mode, tx_ill, rx_ill;
    logic [WW-1:0] unused_tx_rdata;
    logic [BW-1:0] unused_rx_sdata;
    logic unused_tx_wa, unused_tx_ba, unused_rx_empty;

    always_comb begin
        st_d = st_q;
        if (xfer_start) st_d.mode = xfer_word ? MODE_WORD : MODE_BYTE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: MODE_BYTE};
        else        st_q <= st_d;
    end

    assign word_mode = (st_q.mode == MODE_WORD);

    qlf_side #(.BUS_FILLS(1'b1), .LANES(LANES), .DEPTH(DEPTH)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (soft_rst),
        .restart    (xfer_start),
        .word_mode  (word_mode),
        .bus_word   (tx_wr_word),
        .bus_byte   (tx_wr_byte),
        .bus_wdata  (tx_wdata),
        .bus_rdata  (unused_tx_rdata),
        .ser_stb    (ser_tx_take),
        .ser_wdata  ('0),
        .ser_rdata  (ser_tx_byte),
        .full       (tx_full),
        .half       (tx_half),
        .empty      (tx_empty),
        .word_avail (unused_tx_wa),
        .byte_avail (unused_tx_ba),
        .illegal    (tx_ill)
    );

    qlf_side #(.BUS_FILLS(1'b0), .LANES(LANES), .DEPTH(DEPTH)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (soft_rst),
        .restart    (xfer_start),
        .word_mode  (word_mode),
        .bus_word   (rx_rd_word),
        .bus_byte   (rx_rd_byte),
        .bus_wdata  ('0),
        .bus_rdata  (rx_rdata),
        .ser_stb    (ser_rx_put),
        .ser_wdata  (ser_rx_byte),
        .ser_rdata  (unused_rx_sdata),
        .full       (rx_full),
        .half       (rx_half),
        .empty      (unused_rx_empty),
        .word_avail (rx_word_avail),
        .byte_avail (rx_byte_avail),
        .illegal    (rx_ill)
    );

    assign illegal_access = tx_ill | rx_ill;
endmodule

// File: rtl/qlf_chk.sv
module qlf_chk (
    input logic clk,
    input logic rst_n,
    input logic soft_rst,
    input logic xfer_start,
    input logic tx_wr_word,
    input logic tx_wr_byte,
    input logic tx_full,
    input logic tx_empty,
    input logic ser_tx_take,
    input logic rx_rd_byte,
    input logic rx_word_avail,
    input logic rx_byte_avail,
    input logic illegal_access
);
    // R9
    word_into_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr_word && tx_full) |=> illegal_access);

    // R9
    byte_from_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd_byte && !rx_byte_avail) |=> illegal_access);

    // R10
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (tx_empty && !rx_byte_avail && !rx_word_avail));

    // R4
    full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && !ser_tx_take && !soft_rst && !xfer_start) |=> tx_full);

    // R2
    empty_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && !tx_wr_word && !tx_wr_byte && !soft_rst && !xfer_start) |=> tx_empty);

    // R6
    word_implies_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_word_avail |-> rx_byte_avail);
endmodule

bind quad_lane_fifo qlf_chk u_chk (.*);

// File: tb/quad_lane_fifo_tb.sv
`timescale 1ns/1ps
module quad_lane_fifo_tb;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, soft_rst, xfer_start, xfer_word;
    logic tx_wr_word, tx_wr_byte, ser_tx_take, ser_rx_put, rx_rd_word, rx_rd_byte;
    logic [31:0] tx_wdata, rx_rdata;
    logic [7:0]  ser_tx_byte, ser_rx_byte;
    logic tx_full, tx_half, tx_empty, rx_full, rx_half, rx_word_avail, rx_byte_avail, illegal_access;

    quad_lane_fifo u_dut (.*);

    int n_run = 0, n_fail = 0;
    bit done = 0;

    // reference model
    logic [7:0] tmem [4][16];
    logic [7:0] rmem [4][16];
    int tcnt[4], trd[4], twr[4], rcnt[4], rrd[4], rwr[4];
    int tsel, rsel;
    bit mode;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int cnt_of(bit tx, int i);
        return tx ? tcnt[i] : rcnt[i];
    endfunction

    function automatic bit f_full(bit tx);
        bit r = 0;
        if (!mode) return cnt_of(tx, 0) == 16;
        for (int i = 0; i < 4; i++) if (cnt_of(tx, i) == 16) r = 1;
        return r;
    endfunction

    function automatic bit f_half(bit tx);
        int s = 0;
        if (!mode) return cnt_of(tx, 0) >= 8;
        for (int i = 0; i < 4; i++) s += cnt_of(tx, i);
        return s >= 32;
    endfunction

    function automatic bit f_all_data(bit tx);
        bit r = 1;
        for (int i = 0; i < 4; i++) if (cnt_of(tx, i) == 0) r = 0;
        return r;
    endfunction

    function automatic bit f_tx_empty();
        bit r = 1;
        if (!mode) return tcnt[0] == 0;
        for (int i = 0; i < 4; i++) if (tcnt[i] != 0) r = 0;
        return r;
    endfunction

    function automatic bit f_all_room(bit tx);
        bit r = 1;
        for (int i = 0; i < 4; i++) if (cnt_of(tx, i) == 16) r = 0;
        return r;
    endfunction

    task automatic idle();
        soft_rst = 0; xfer_start = 0;
        tx_wr_word = 0; tx_wr_byte = 0; ser_tx_take = 0;
        ser_rx_put = 0; rx_rd_word = 0; rx_rd_byte = 0;
    endtask

    // inputs are driven at posedge+1; this advances one clock and checks
    task automatic step();
        bit tboth, twok, tbok, tsok, rboth, rwok, rbok, rsok, exp_ill;
        int tl, rl;
        logic [31:0] wexp;
        #1;
        tl = mode ? tsel : 0;
        rl = mode ? rsel : 0;
        tboth = tx_wr_word && tx_wr_byte;
        twok  = tx_wr_word && !tboth && f_all_room(1);
        tbok  = tx_wr_byte && !tboth && tcnt[0] < 16;
        tsok  = ser_tx_take && tcnt[tl] > 0;
        rboth = rx_rd_word && rx_rd_byte;
        rwok  = rx_rd_word && !rboth && f_all_data(0);
        rbok  = rx_rd_byte && !rboth && rcnt[0] > 0;
        rsok  = ser_rx_put && rcnt[rl] < 16;
        exp_ill = ((tx_wr_word || tx_wr_byte) && !(twok || tbok)) || (ser_tx_take && !tsok)
               || ((rx_rd_word || rx_rd_byte) && !(rwok || rbok)) || (ser_rx_put && !rsok);

        if (tsok) chk(mode ? "R2" : "R3", "serial tx byte", 32'(ser_tx_byte), 32'(tmem[tl][trd[tl]]));
        if (rwok) begin
            for (int i = 0; i < 4; i++) wexp[8*i +: 8] = rmem[i][rrd[i]];
            chk("R6", "rx word data", rx_rdata, wexp);
        end
        if (rbok) chk("R7", "rx byte data", 32'(rx_rdata[7:0]), 32'(rmem[0][rrd[0]]));

        if (soft_rst) begin
            for (int i = 0; i < 4; i++) begin
                tcnt[i] = 0; trd[i] = 0; twr[i] = 0; rcnt[i] = 0; rrd[i] = 0; rwr[i] = 0;
            end
            tsel = 0; rsel = 0;
        end else begin
            if (tsok) begin trd[tl] = (trd[tl] + 1) % 16; tcnt[tl]--; end
            if (twok) for (int i = 0; i < 4; i++) begin
                tmem[i][twr[i]] = tx_wdata[8*i +: 8]; twr[i] = (twr[i] + 1) % 16; tcnt[i]++;
            end
            if (tbok) begin tmem[0][twr[0]] = tx_wdata[7:0]; twr[0] = (twr[0] + 1) % 16; tcnt[0]++; end
            if (rsok) begin rmem[rl][rwr[rl]] = ser_rx_byte; rwr[rl] = (rwr[rl] + 1) % 16; rcnt[rl]++; end
            if (rwok) for (int i = 0; i < 4; i++) begin rrd[i] = (rrd[i] + 1) % 16; rcnt[i]--; end
            if (rbok) begin rrd[0] = (rrd[0] + 1) % 16; rcnt[0]--; end
            if (xfer_start) begin tsel = 0; rsel = 0; end
            else if (mode) begin
                if (tsok) tsel = (tsel + 1) % 4;
                if (rsok) rsel = (rsel + 1) % 4;
            end
        end
        if (xfer_start) mode = xfer_word;

        @(posedge clk); #1;
        chk("R4", "tx_full", 32'(tx_full), 32'(f_full(1)));
        chk("R5", "tx_half", 32'(tx_half), 32'(f_half(1)));
        chk("R2", "tx_empty", 32'(tx_empty), 32'(f_tx_empty()));
        chk("R8", "rx_full", 32'(rx_full), 32'(f_full(0)));
        chk("R8", "rx_half", 32'(rx_half), 32'(f_half(0)));
        chk("R6", "rx_word_avail", 32'(rx_word_avail), 32'(f_all_data(0)));
        chk("R7", "rx_byte_avail", 32'(rx_byte_avail), 32'(rcnt[0] > 0));
        chk("R9", "illegal_access", 32'(illegal_access), 32'(exp_ill));
        idle();
    endtask

    task automatic start(bit w);
        xfer_start = 1; xfer_word = w; step();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd4711);
        for (int i = 0; i < 4; i++) begin
            tcnt[i] = 0; trd[i] = 0; twr[i] = 0; rcnt[i] = 0; rrd[i] = 0; rwr[i] = 0;
        end
        tsel = 0; rsel = 0; mode = 0;
        idle(); xfer_word = 0; tx_wdata = '0; ser_rx_byte = '0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(posedge clk); #1;
        chk("R1", "tx_empty after reset", 32'(tx_empty), 32'd1);
        chk("R1", "tx_full after reset", 32'(tx_full), 32'd0);
        chk("R1", "rx_byte_avail after reset", 32'(rx_byte_avail), 32'd0);
        chk("R1", "rx_word_avail after reset", 32'(rx_word_avail), 32'd0);
        chk("R1", "illegal after reset", 32'(illegal_access), 32'd0);

        // R11: xfer_word alone does not switch mode; byte capacity stays 16
        xfer_word = 1;
        for (int i = 0; i < 16; i++) begin tx_wr_byte = 1; tx_wdata = 32'(i + 8'hA0); step(); end
        chk("R11", "tx_full in byte mode without start", 32'(tx_full), 32'd1);
        tx_wr_byte = 1; tx_wdata = 32'h55; step();        // R3/R9 one past capacity
        for (int i = 0; i < 17; i++) begin ser_tx_take = 1; step(); end

        // R4/R2: word mode capacity and lane order
        start(1);
        for (int i = 0; i < 17; i++) begin
            tx_wr_word = 1; tx_wdata = {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)}; step();
        end
        for (int i = 0; i < 65; i++) begin ser_tx_take = 1; step(); end

        // R6: three bytes are not a word, fourth completes it
        for (int i = 0; i < 3; i++) begin ser_rx_put = 1; ser_rx_byte = 8'(8'h30 + i); step(); end
        rx_rd_word = 1; step();
        ser_rx_put = 1; ser_rx_byte = 8'h33; step();
        rx_rd_word = 1; step();

        // R10: soft reset clears both sides
        for (int i = 0; i < 5; i++) begin tx_wr_word = 1; ser_rx_put = 1; ser_rx_byte = 8'(i); step(); end
        soft_rst = 1; tx_wr_word = 1; step();
        chk("R10", "tx_empty after soft reset", 32'(tx_empty), 32'd1);
        chk("R10", "rx_byte_avail after soft reset", 32'(rx_byte_avail), 32'd0);

        // random phase
        for (int t = 0; t < 50; t++) begin
            start(1'($urandom_range(0, 1)));
            for (int c = 0; c < 60; c++) begin
                tx_wr_word  = ($urandom_range(0, 9) < 3);
                tx_wr_byte  = ($urandom_range(0, 9) < 2);
                tx_wdata    = $urandom;
                ser_tx_take = ($urandom_range(0, 9) < 3);
                ser_rx_put  = ($urandom_range(0, 9) < 4);
                ser_rx_byte = 8'($urandom);
                rx_rd_word  = ($urandom_range(0, 9) < 2);
                rx_rd_byte  = ($urandom_range(0, 9) < 2);
                soft_rst    = ($urandom_range(0, 99) == 0);
                step();
            end
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule